// File: doc/BRIEF.md
# Write-Through Byte Cache with LRU Replacement

This block is a very small data cache placed between a byte-wide processor load/store port and a byte-addressed backing memory. Any line can hold any block, so the cache is fully associative. Each line stores one two-byte block, a valid bit and a tag. Lines carry no dirty state. Every store goes to memory straight away, including stores that hit. A store that misses first brings its block into the cache and then writes its byte into the cache and into memory.

The processor holds `req_valid` together with its command, address and store data until it sees `req_ready` high on a rising clock edge. A load that hits completes in the cycle it is presented, with `req_ready` raised combinationally. All other accesses wait while a block fill or a memory byte write is in progress. Memory is reached through two paths, each with its own handshake: a block-read path that returns a whole block, and a byte-write path that is acknowledged. Two counters report how many accesses hit and how many missed.

Top module: `wt_byte_cache`

## Requirements
- R1: After a synchronous active-low reset, both counters read zero, `req_ready` is low while no request is presented, and every line is invalid, so the first access of any block misses.
- R2: The 4-bit byte address is split into a tag in bits [3:1] and a byte offset in bit [0]. Two bytes that share a tag live in the same line, so after one of them is brought in, the other hits.
- R3: On a miss, the cache drives `mem_rd_addr` with the tag. It takes `mem_rd_data[7:0]` as the byte at offset 0 and `mem_rd_data[15:8]` as the byte at offset 1. A load miss returns the addressed byte from that block.
- R4: A load hit returns its byte with `req_ready` high in the same cycle it is presented, and makes no memory request.
- R5: Every store, hit or miss, drives `mem_wr_addr` with the full byte address and `mem_wr_data` with the store byte, and leaves that byte in memory.
- R6: A store miss allocates its line. The block is read first and the store byte is then merged into it, so later loads of both bytes of that block hit: the stored byte comes back together with the other byte as read from memory.
- R7: When a miss occurs while an invalid line exists, an invalid line is filled and no valid line is evicted.
- R8: When all lines are valid, a miss replaces the least recently used line. Every access, load or store, hit or miss, makes the line it touches the most recently used.
- R9: Replacing a line never writes to memory. Only stores raise `mem_wr_req`, and each store writes exactly one byte.
- R10: Each accepted access adds exactly one to `hit_count` or to `miss_count`, whichever matches its lookup outcome.
- R11: `req_ready` stays low while a block fill or a memory byte write is outstanding.
- R12: Starting from an empty cache, the sequence load 1, load 7, store 0, store 5, load 10, store 5, store 10 gives miss, miss, hit, miss, miss, hit, hit. The run ends with 4 misses, 3 hits, 8 bytes read from memory and 4 bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Processor request present, held until accepted |
| req_write | input | 1 | 1 = store byte, 0 = load byte |
| req_addr | input | 4 | Byte address |
| req_wdata | input | 8 | Store byte |
| req_ready | output | 1 | Request completes on this clock edge |
| rsp_rdata | output | 8 | Load byte, valid while req_ready is high for a load |
| mem_rd_req | output | 1 | Block read request, held until mem_rd_valid |
| mem_rd_addr | output | 3 | Block address (tag) to read |
| mem_rd_valid | input | 1 | Block read data present |
| mem_rd_data | input | 16 | Block data, offset 0 in the low byte |
| mem_wr_req | output | 1 | Byte write request, held until mem_wr_ack |
| mem_wr_addr | output | 4 | Byte address to write |
| mem_wr_data | output | 8 | Byte to write |
| mem_wr_ack | input | 1 | Byte write accepted |
| hit_count | output | 8 | Number of accesses that hit |
| miss_count | output | 8 | Number of accesses that missed |

## Verification
A store miss is the case where block allocation and the store merge affect the same line back to back. The fill writes the whole block into the chosen line, and the byte write that follows overwrites one half of it. The bench provokes this with a store to an uncached block whose other byte is known in the memory model. It then loads both bytes of the block. Both loads must hit, one must return the stored value and the other the original memory byte, and the memory write count must have risen by exactly one.

// File: rtl/wtc_pkg.sv
// Package: shared types for the write-through byte cache.
// Assumes: used by wt_byte_cache and its sub-blocks only.
package wtc_pkg;

    // Controller states: waiting, block fill, memory byte write, completion.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } wtc_state_e;

endpackage

// File: rtl/wtc_lines.sv
// Module: wtc_lines
// Holds valid bits, tags and block data for every line and compares the
// lookup tag against all lines in parallel. Accepts a whole-block fill and a
// single-byte merge. The two never target the same cycle.
// Assumes: the controller never fills a tag that is already present.
module wtc_lines #(
    parameter int LINES  = 2,
    parameter int TAG_W  = 3,
    parameter int OFFS_W = 1,
    parameter int DATA_W = 8,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int BLK_W  = DATA_W << OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lookup_tag,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [BLK_W-1:0]  fill_block,
    input  logic              merge_en,
    input  logic [LINE_W-1:0] merge_line,
    input  logic [OFFS_W-1:0] merge_off,
    input  logic [DATA_W-1:0] merge_byte,
    input  logic [LINE_W-1:0] rd_line,
    output logic [LINES-1:0]  hit_vec,
    output logic [LINES-1:0]  valid_vec,
    output logic [BLK_W-1:0]  rd_block
);

    logic [TAG_W-1:0] tag_q  [LINES];
    logic [BLK_W-1:0] data_q [LINES];

    // Line storage: valid cleared by reset, fill installs a block, merge writes one byte.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                valid_vec[i] <= 1'b0;
            end else if (fill_en && fill_line == LINE_W'(i)) begin
                valid_vec[i] <= 1'b1;
                tag_q[i]     <= lookup_tag;
                data_q[i]    <= fill_block;
            end else if (merge_en && merge_line == LINE_W'(i)) begin
                data_q[i][int'(merge_off)*DATA_W +: DATA_W] <= merge_byte;
            end
        end
    end

    // Parallel tag match against every valid line.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            hit_vec[i] = valid_vec[i] && (tag_q[i] == lookup_tag);
        end
    end

    assign rd_block = data_q[rd_line];

    // R2: one tag is never held in two lines at once.
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/wtc_lru.sv
// Module: wtc_lru
// Age-based least-recently-used tracker. Age 0 means most recent and age
// LINES-1 means oldest. Picks the lowest invalid line if one exists, and the
// oldest line otherwise.
// Assumes: ages form a permutation of 0..LINES-1 from reset onwards.
module wtc_lru #(
    parameter int LINES = 2,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_en,
    input  logic [LINE_W-1:0] touch_line,
    input  logic [LINES-1:0]  valid_vec,
    output logic [LINE_W-1:0] victim_line
);

    logic [LINE_W-1:0] age_q [LINES];
    logic [LINES-1:0]  oldest_vec;
    logic              found_free;

    // Age update: touched line becomes youngest, younger lines age by one.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                age_q[i] <= LINE_W'(LINES - 1 - i);
            end else if (touch_en) begin
                if (touch_line == LINE_W'(i)) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < age_q[touch_line]) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // Victim choice: lowest invalid line first, otherwise the oldest.
    always_comb begin
        victim_line = '0;
        found_free  = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            oldest_vec[i] = (age_q[i] == LINE_W'(LINES - 1));
        end
        for (int i = 0; i < LINES; i++) begin
            if (!valid_vec[i] && !found_free) begin
                victim_line = LINE_W'(i);
                found_free  = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < LINES; i++) begin
                if (oldest_vec[i]) victim_line = LINE_W'(i);
            end
        end
    end

    // R8: exactly one line is the oldest at any time.
    p_one_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

endmodule

// File: rtl/wt_byte_cache.sv
// Module: wt_byte_cache (top)
// Fully associative write-through cache with write-allocate and LRU
// replacement. Load hits complete in the cycle they are presented. Misses
// fill a whole block first. Stores always write one byte to memory.
// Assumes: the processor holds its request stable until req_ready, and memory
// holds nothing back once it has answered a request.
module wt_byte_cache
    import wtc_pkg::*;
#(
    parameter int LINES  = 2,
    parameter int ADDR_W = 4,
    parameter int OFFS_W = 1,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    localparam int TAG_W  = ADDR_W - OFFS_W,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int BLK_W  = DATA_W << OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_req,
    output logic [TAG_W-1:0]  mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [BLK_W-1:0]  mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    wtc_state_e        state_q;
    logic [LINE_W-1:0] line_q;
    logic [TAG_W-1:0]  req_tag;
    logic [OFFS_W-1:0] req_off;
    logic [LINES-1:0]  hit_vec;
    logic [LINES-1:0]  valid_vec;
    logic              hit;
    logic [LINE_W-1:0] hit_line;
    logic [LINE_W-1:0] victim_line;
    logic [LINE_W-1:0] rd_line;
    logic [BLK_W-1:0]  rd_block;
    logic              lookup;
    logic              fill_en;
    logic              merge_en;

    assign req_tag = req_addr[ADDR_W-1:OFFS_W];
    assign req_off = req_addr[OFFS_W-1:0];
    assign hit     = |hit_vec;
    assign lookup  = (state_q == ST_IDLE) && req_valid;
    assign fill_en  = (state_q == ST_FILL)  && mem_rd_valid;
    assign merge_en = (state_q == ST_WRITE) && mem_wr_ack;

    // Encode the matching line number from the hit vector.
    always_comb begin
        hit_line = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hit_vec[i]) hit_line = LINE_W'(i);
        end
    end

    assign rd_line   = (state_q == ST_IDLE) ? hit_line : line_q;
    assign rsp_rdata = rd_block[int'(req_off)*DATA_W +: DATA_W];
    assign req_ready = (lookup && hit && !req_write) || (state_q == ST_RESP);

    assign mem_rd_req  = (state_q == ST_FILL);
    assign mem_rd_addr = req_tag;
    assign mem_wr_req  = (state_q == ST_WRITE);
    assign mem_wr_addr = req_addr;
    assign mem_wr_data = req_wdata;

    wtc_lines #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .OFFS_W(OFFS_W),
        .DATA_W(DATA_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .lookup_tag(req_tag),
        .fill_en   (fill_en),
        .fill_line (line_q),
        .fill_block(mem_rd_data),
        .merge_en  (merge_en),
        .merge_line(line_q),
        .merge_off (req_off),
        .merge_byte(req_wdata),
        .rd_line   (rd_line),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .rd_block  (rd_block)
    );

    wtc_lru #(
        .LINES(LINES)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (lookup),
        .touch_line (hit ? hit_line : victim_line),
        .valid_vec  (valid_vec),
        .victim_line(victim_line)
    );

    // Controller: lookup, optional fill, optional memory write, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!hit) begin
                            state_q <= ST_FILL;
                            line_q  <= victim_line;
                        end else if (req_write) begin
                            state_q <= ST_WRITE;
                            line_q  <= hit_line;
                        end
                    end
                end
                ST_FILL:  if (mem_rd_valid) state_q <= req_write ? ST_WRITE : ST_RESP;
                ST_WRITE: if (mem_wr_ack)   state_q <= ST_RESP;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Access counters: one step per lookup, by outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (lookup) begin
            if (hit) hit_count  <= hit_count + 1'b1;
            else     miss_count <= miss_count + 1'b1;
        end
    end

    logic [CNT_W:0] total_count;
    assign total_count = {1'b0, hit_count} + {1'b0, miss_count};

    // R11: no completion while memory traffic is outstanding.
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> !req_ready);

    // R9: memory writes belong to stores only, never to evictions.
    p_no_evict_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (req_valid && req_write));

    // R10: the counters advance by at most one access per cycle.
    p_one_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (total_count - $past(total_count)) <= 1);

    // R6: a store miss writes memory right after its fill completes.
    p_store_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_rd_req) && req_write) |-> mem_wr_req);

    // R4: a completing load hit issues no memory request.
    p_load_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |-> (!mem_rd_req && !mem_wr_req));

endmodule

// File: tb/tb_wt_byte_cache.sv
module tb_wt_byte_cache;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [3:0]  req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        mem_rd_req;
    logic [2:0]  mem_rd_addr;
    logic        mem_rd_valid;
    logic [15:0] mem_rd_data;
    logic        mem_wr_req;
    logic [3:0]  mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic        mem_wr_ack;
    logic [7:0]  hit_count, miss_count;

    int total = 0;
    int bad = 0;
    int rd_bytes, wr_bytes;
    int rd_wait;
    logic done = 1'b0;
    logic [7:0] mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_byte_cache dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [7:0] init_byte(int a);
        case (a)
            0: return 8'd78;   1: return 8'd29;   2: return 8'd120;  3: return 8'd123;
            4: return 8'd71;   5: return 8'd150;  6: return 8'd162;  7: return 8'd173;
            8: return 8'd21;   9: return 8'd18;   10: return 8'd28;  11: return 8'd33;
            12: return 8'd200; 13: return 8'd19;  14: return 8'd225; default: return 8'd210;
        endcase
    endfunction

    // Memory model: block read after two cycles, byte write acknowledged next cycle.
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        mem_wr_ack   <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_byte(i);
            rd_bytes <= 0;
            wr_bytes <= 0;
            rd_wait  <= 0;
        end else begin
            if (mem_rd_req && !mem_rd_valid) begin
                if (rd_wait == 1) begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= {mem[{mem_rd_addr, 1'b1}], mem[{mem_rd_addr, 1'b0}]};
                    rd_bytes     <= rd_bytes + 2;
                    rd_wait      <= 0;
                end else begin
                    rd_wait <= rd_wait + 1;
                end
            end else begin
                rd_wait <= 0;
            end
            if (mem_wr_req && !mem_wr_ack) begin
                mem[mem_wr_addr] <= mem_wr_data;
                mem_wr_ack       <= 1'b1;
                wr_bytes         <= wr_bytes + 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One processor access; reports load data, hit outcome and wait cycles.
    task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output logic was_hit, output int waits);
        int h0;
        h0 = hit_count;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        waits = 0;
        while (!req_ready && waits < 100) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = rsp_rdata;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        was_hit = (int'(hit_count) != h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // {write, addr, wdata, expected hit, expected load data}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 4'd1,  8'd0,  1'b0, 8'd29},
        {1'b0, 4'd7,  8'd0,  1'b0, 8'd173},
        {1'b1, 4'd0,  8'd173,1'b1, 8'd0},
        {1'b1, 4'd5,  8'd29, 1'b0, 8'd0},
        {1'b0, 4'd10, 8'd0,  1'b0, 8'd28},
        {1'b1, 4'd5,  8'd29, 1'b1, 8'd0},
        {1'b1, 4'd10, 8'd29, 1'b1, 8'd0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       h;
        int         wt;
        int         wb0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        do_reset();

        // R1: reset state
        check(hit_count == 0, "R1 hit_count", hit_count, 0);
        check(miss_count == 0, "R1 miss_count", miss_count, 0);
        check(!req_ready, "R1 ready idle", req_ready, 0);

        // R12: reference sequence walked from the table
        for (int k = 0; k < NVEC; k++) begin
            wb0 = wr_bytes;
            access(VEC[k][21], VEC[k][20:17], VEC[k][16:9], rd, h, wt);
            check(h == VEC[k][8], "R12 hit pattern", h, VEC[k][8]);
            if (!VEC[k][21]) begin
                check(rd == VEC[k][7:0], "R3 load data", rd, VEC[k][7:0]);
                check(wr_bytes == wb0, "R9 load writes none", wr_bytes, wb0);
            end else begin
                check(wr_bytes == wb0 + 1, "R5 store writes one byte", wr_bytes, wb0 + 1);
            end
            if (h && !VEC[k][21]) check(wt == 0, "R4 hit waits", wt, 0);
            if (!h) check(wt > 0, "R11 miss stalls", wt, 1);
        end
        check(miss_count == 4, "R12 misses", miss_count, 4);
        check(hit_count == 3, "R12 hits", hit_count, 3);
        check(rd_bytes == 8, "R12 bytes read", rd_bytes, 8);
        check(wr_bytes == 4, "R12 bytes written", wr_bytes, 4);
        check(mem[0] == 8'd173, "R5 mem0", mem[0], 173);
        check(mem[5] == 8'd29, "R5 mem5", mem[5], 29);
        check(mem[10] == 8'd29, "R5 mem10", mem[10], 29);

        // R1: reset clears lines and counters
        do_reset();
        check(hit_count == 0 && miss_count == 0, "R1 counters cleared", hit_count + miss_count, 0);
        access(1'b0, 4'd1, 8'd0, rd, h, wt);
        check(!h, "R1 lines invalid after reset", h, 0);

        // R7, R2: second block fills the free line, same-block byte hits
        access(1'b0, 4'd2, 8'd0, rd, h, wt);
        check(rd == 8'd120, "R3 load miss data", rd, 120);
        access(1'b0, 4'd0, 8'd0, rd, h, wt);
        check(h, "R7 free line used first", h, 1);
        check(rd == 8'd78, "R2 offset 0 byte", rd, 78);

        // R8: LRU victim after touch
        access(1'b0, 4'd4, 8'd0, rd, h, wt);
        check(!h && rd == 8'd71, "R8 miss into LRU line", rd, 71);
        access(1'b0, 4'd1, 8'd0, rd, h, wt);
        check(h, "R8 recently used block kept", h, 1);
        access(1'b0, 4'd3, 8'd0, rd, h, wt);
        check(!h, "R8 evicted block misses", h, 0);
        check(rd == 8'd123, "R3 offset 1 byte", rd, 123);

        // R6: store miss allocates and merges
        wb0 = wr_bytes;
        access(1'b1, 4'd9, 8'h55, rd, h, wt);
        check(!h, "R6 store miss", h, 0);
        access(1'b0, 4'd8, 8'd0, rd, h, wt);
        check(h && rd == 8'd21, "R6 other byte from memory", rd, 21);
        access(1'b0, 4'd9, 8'd0, rd, h, wt);
        check(h && rd == 8'h55, "R6 stored byte merged", rd, 8'h55);
        check(mem[9] == 8'h55, "R5 store miss reaches memory", mem[9], 8'h55);
        access(1'b0, 4'd3, 8'd0, rd, h, wt);
        check(h, "R8 store touched LRU", h, 1);
        check(wr_bytes == wb0 + 1, "R9 evictions write nothing", wr_bytes, wb0 + 1);
        check(int'(hit_count) + int'(miss_count) == 10, "R10 one count per access",
              int'(hit_count) + int'(miss_count), 10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule